// File: doc/BRIEF.md
# Transmit Staging Buffer with Byte-Count Commit

This block is the transmit half of a serial port. Software places outgoing bytes into a 1024-byte staging window. Each byte is addressed by an offset that counts from the current write pointer. Staged bytes are not yet part of the transmit queue. Software hands them over by writing a byte count N to the commit input. The block then moves its write pointer forward by N and raises its fill count by N.

On the drain side the block shows the oldest committed byte to a serializer with a valid/ready handshake, and takes one byte per accepted transfer. A status word carries the fill count and the write pointer. At most 1020 bytes may be outstanding, and a commit that asks for more is trimmed to the space that is free. A space-available interrupt, gated by an enable bit, is asserted while the fill count is at or below a threshold. The threshold comes from a 3-bit trigger level.

Top module: `tfq_tx_stage`

## Requirements
- R1: After reset the fill count and the write pointer read zero, no byte is offered (tx_valid_o low), tx_empty_o is high and free_o reads 1020.
- R2: A window write stores win_data_i at address (write pointer + win_off_i) mod 1024. It changes neither the fill count nor the write pointer, and the byte is not offered until a commit covers it.
- R3: A commit of N moves the write pointer forward by N (mod 1024) and raises the fill count by N, both visible one cycle later. ctrl_rdata_o holds the fill count in bits 25:16 and the write pointer in bits 9:0, and every other bit is zero. A commit of 0 changes nothing.
- R4: The fill count never exceeds 1020. A commit larger than free space is trimmed to 1020 minus the fill count, and free_o always equals 1020 minus the fill count.
- R5: tx_valid_o is high exactly when the fill count is nonzero, and tx_data_o is the oldest committed byte, so bytes leave in commit order. Each cycle with tx_valid_o and tx_ready_i both high removes one byte. tx_ready_i has no effect while nothing is offered.
- R6: A commit of N and an accepted byte in the same cycle leave the fill count at old + N − 1.
- R7: The threshold is 4 << trig_lvl_i bytes, so level 5 gives 128, level 0 gives 4 and level 7 gives 512. space_irq_o is high when space_ie_i is set and the fill count is at or below the threshold.
- R8: space_irq_o is low whenever space_ie_i is low.
- R9: tx_empty_o is high exactly when the fill count is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| win_we_i | input | 1 | Staging window write strobe |
| win_off_i | input | 10 | Byte offset from the write pointer |
| win_data_i | input | 8 | Byte to stage |
| commit_we_i | input | 1 | Commit strobe |
| commit_cnt_i | input | 10 | Number of staged bytes to commit |
| ctrl_rdata_o | output | 32 | Status word: fill count 25:16, write pointer 9:0 |
| free_o | output | 10 | Free space, 1020 minus fill count |
| trig_lvl_i | input | 3 | Space interrupt trigger level |
| space_ie_i | input | 1 | Space interrupt enable |
| space_irq_o | output | 1 | Space-available interrupt |
| tx_valid_o | output | 1 | A committed byte is offered |
| tx_data_o | output | 8 | Oldest committed byte |
| tx_ready_i | input | 1 | Serializer takes the offered byte |
| tx_empty_o | output | 1 | No committed bytes remain |

## Verification
A wrong fill count shows at once in the status word, in free_o, in tx_valid_o and in the interrupt, and it does so in the cycle after the faulty commit or accept. A wrong read or write pointer shows as a wrong byte on tx_data_o the next time that location is offered. A pointer slip caused by offset wrapping can therefore stay hidden until the queue drains past the wrap point. For that reason the stimulus includes committed runs that cross address 1023, and it compares every offered byte on every clock.

// File: rtl/tfq_pkg.sv
package tfq_pkg;

   // What to do with a commit that asks for more than the free space
   typedef enum logic [0:0] {
      OVF_CLAMP = 1'b0,   // grant as much as fits
      OVF_DROP  = 1'b1    // grant nothing
   } ovf_policy_e;

endpackage

// File: rtl/tfq_stage_ram.sv
module tfq_stage_ram #(
   parameter int unsigned AW = 10,
   parameter int unsigned DW = 8
) (
   input  logic          clk_i,
   input  logic          we_i,
   input  logic [AW-1:0] waddr_i,
   input  logic [DW-1:0] wdata_i,
   input  logic [AW-1:0] raddr_i,
   output logic [DW-1:0] rdata_o
);
   localparam int unsigned DEPTH = 1 << AW;

   logic [DW-1:0] mem_q [DEPTH];

   always_ff @(posedge clk_i) begin
      if (we_i) mem_q[waddr_i] <= wdata_i;
   end

   assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/tfq_ptr_ctrl.sv
module tfq_ptr_ctrl
   import tfq_pkg::*;
#(
   parameter int unsigned AW         = 10,
   parameter int unsigned RESERVE    = 4,
   parameter ovf_policy_e OVF_POLICY = OVF_CLAMP
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          commit_we_i,
   input  logic [AW-1:0] commit_cnt_i,
   input  logic          pop_i,
   output logic [AW-1:0] wptr_o,
   output logic [AW-1:0] rptr_o,
   output logic [AW-1:0] fill_o,
   output logic [AW-1:0] free_o
);
   localparam int unsigned DEPTH = 1 << AW;
   localparam int unsigned LIMIT = DEPTH - RESERVE;

   logic [AW-1:0] wptr_q, rptr_q, fill_q;
   logic [AW-1:0] free_s, grant_s;

   assign free_s = AW'(LIMIT) - fill_q;

   generate
      if (OVF_POLICY == OVF_CLAMP) begin : g_clamp
         always_comb begin
            if (!commit_we_i)               grant_s = '0;
            else if (commit_cnt_i > free_s) grant_s = free_s;
            else                            grant_s = commit_cnt_i;
         end
      end else begin : g_drop
         always_comb begin
            if (!commit_we_i || commit_cnt_i > free_s) grant_s = '0;
            else                                       grant_s = commit_cnt_i;
         end
      end
   endgenerate

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         wptr_q <= '0;
         rptr_q <= '0;
         fill_q <= '0;
      end else begin
         wptr_q <= wptr_q + grant_s;
         rptr_q <= rptr_q + AW'(pop_i);
         fill_q <= fill_q + grant_s - AW'(pop_i);
      end
   end

   assign wptr_o = wptr_q;
   assign rptr_o = rptr_q;
   assign fill_o = fill_q;
   assign free_o = free_s;
endmodule

// File: rtl/tfq_space_irq.sv
module tfq_space_irq #(
   parameter int unsigned AW         = 10,
   parameter int unsigned LVL_W      = 3,
   parameter int unsigned BASE_SHIFT = 2
) (
   input  logic [AW-1:0]    fill_i,
   input  logic [LVL_W-1:0] lvl_i,
   input  logic             ie_i,
   output logic             irq_o
);
   localparam int unsigned NLVL = 1 << LVL_W;

   logic [AW:0] thr_tab [NLVL];
   logic [AW:0] thr_s;

   generate
      for (genvar i = 0; i < NLVL; i++) begin : g_thr
         localparam int unsigned SH = i + BASE_SHIFT;
         assign thr_tab[i] = (AW+1)'(1) << SH;
      end
   endgenerate

   assign thr_s = thr_tab[lvl_i];
   assign irq_o = ie_i && ({1'b0, fill_i} <= thr_s);
endmodule

// File: rtl/tfq_tx_stage.sv
module tfq_tx_stage
   import tfq_pkg::*;
#(
   parameter int unsigned ADDR_W     = 10,
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned RESERVE    = 4,
   parameter int unsigned LVL_W      = 3,
   parameter int unsigned LVL_SHIFT  = 2,
   parameter int unsigned CTRL_W     = 32,
   parameter int unsigned FILL_LSB   = 16,
   parameter ovf_policy_e OVF_POLICY = OVF_CLAMP
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              win_we_i,
   input  logic [ADDR_W-1:0] win_off_i,
   input  logic [DATA_W-1:0] win_data_i,
   input  logic              commit_we_i,
   input  logic [ADDR_W-1:0] commit_cnt_i,
   output logic [CTRL_W-1:0] ctrl_rdata_o,
   output logic [ADDR_W-1:0] free_o,
   input  logic [LVL_W-1:0]  trig_lvl_i,
   input  logic              space_ie_i,
   output logic              space_irq_o,
   output logic              tx_valid_o,
   output logic [DATA_W-1:0] tx_data_o,
   input  logic              tx_ready_i,
   output logic              tx_empty_o
);
   localparam int unsigned DEPTH   = 1 << ADDR_W;
   localparam int unsigned MAX_SHF = (1 << LVL_W) - 1 + LVL_SHIFT;

   // elaboration-time parameter checks
   generate
      if (RESERVE < 1 || RESERVE >= DEPTH) begin : g_bad_reserve
         $error("RESERVE must lie in 1..DEPTH-1");
      end
      if (FILL_LSB < ADDR_W || FILL_LSB + ADDR_W > CTRL_W) begin : g_bad_layout
         $error("status word fields overlap or overflow");
      end
      if (MAX_SHF > ADDR_W) begin : g_bad_level
         $error("largest trigger threshold does not fit the fill count");
      end
   endgenerate

   logic [ADDR_W-1:0] wptr_s, rptr_s, fill_s;
   logic [ADDR_W-1:0] waddr_s;
   logic              pop_s;

   assign tx_valid_o = (fill_s != '0);
   assign tx_empty_o = (fill_s == '0);
   assign pop_s      = tx_valid_o && tx_ready_i;
   assign waddr_s    = wptr_s + win_off_i;

   tfq_stage_ram #(
      .AW (ADDR_W),
      .DW (DATA_W)
   ) i_ram (
      .clk_i   (clk_i),
      .we_i    (win_we_i),
      .waddr_i (waddr_s),
      .wdata_i (win_data_i),
      .raddr_i (rptr_s),
      .rdata_o (tx_data_o)
   );

   tfq_ptr_ctrl #(
      .AW         (ADDR_W),
      .RESERVE    (RESERVE),
      .OVF_POLICY (OVF_POLICY)
   ) i_ptr (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .commit_we_i  (commit_we_i),
      .commit_cnt_i (commit_cnt_i),
      .pop_i        (pop_s),
      .wptr_o       (wptr_s),
      .rptr_o       (rptr_s),
      .fill_o       (fill_s),
      .free_o       (free_o)
   );

   tfq_space_irq #(
      .AW         (ADDR_W),
      .LVL_W      (LVL_W),
      .BASE_SHIFT (LVL_SHIFT)
   ) i_irq (
      .fill_i (fill_s),
      .lvl_i  (trig_lvl_i),
      .ie_i   (space_ie_i),
      .irq_o  (space_irq_o)
   );

   always_comb begin
      ctrl_rdata_o                       = '0;
      ctrl_rdata_o[ADDR_W-1:0]           = wptr_s;
      ctrl_rdata_o[FILL_LSB +: ADDR_W]   = fill_s;
   end
endmodule

// File: rtl/tfq_tx_stage_chk.sv
module tfq_tx_stage_chk #(
   parameter int unsigned AW      = 10,
   parameter int unsigned RESERVE = 4
) (
   input logic          clk_i,
   input logic          rst_ni,
   input logic          commit_we_i,
   input logic [AW-1:0] commit_cnt_i,
   input logic [AW-1:0] fill_i,
   input logic [AW-1:0] wptr_i,
   input logic [AW-1:0] free_i,
   input logic          space_ie_i,
   input logic          space_irq_i,
   input logic          tx_valid_i,
   input logic          tx_ready_i,
   input logic          tx_empty_i
);
   localparam int unsigned LIMIT = (1 << AW) - RESERVE;

   logic pop_s;
   assign pop_s = tx_valid_i && tx_ready_i;

   // R4
   fill_limit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      int'(fill_i) <= LIMIT);

   // R3
   commit_adv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (commit_we_i && !pop_s && commit_cnt_i <= free_i)
      |=> (fill_i == $past(fill_i) + $past(commit_cnt_i))
          && (wptr_i == $past(wptr_i) + $past(commit_cnt_i)));

   // R5
   pop_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pop_s && !commit_we_i) |=> fill_i == $past(fill_i) - 1'b1);

   // R2
   stage_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!commit_we_i && !pop_s) |=> $stable(fill_i) && $stable(wptr_i));

   // R8
   irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !space_ie_i |-> !space_irq_i);

   // R7
   irq_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (space_ie_i && tx_empty_i) |-> space_irq_i);

   // R9
   empty_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tx_empty_i != tx_valid_i);
endmodule

bind tfq_tx_stage tfq_tx_stage_chk #(
   .AW      (ADDR_W),
   .RESERVE (RESERVE)
) i_tfq_chk (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .commit_we_i  (commit_we_i),
   .commit_cnt_i (commit_cnt_i),
   .fill_i       (ctrl_rdata_o[FILL_LSB +: ADDR_W]),
   .wptr_i       (ctrl_rdata_o[ADDR_W-1:0]),
   .free_i       (free_o),
   .space_ie_i   (space_ie_i),
   .space_irq_i  (space_irq_o),
   .tx_valid_i   (tx_valid_o),
   .tx_ready_i   (tx_ready_i),
   .tx_empty_i   (tx_empty_o)
);

// File: tb/test_tfq_tx_stage.sv
`timescale 1ns/1ps
module test_tfq_tx_stage;
   localparam int DEPTH = 1024;
   localparam int LIMIT = 1020;
   localparam int WDOG  = 150000;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        win_we;
   logic [9:0]  win_off;
   logic [7:0]  win_data;
   logic        commit_we;
   logic [9:0]  commit_cnt;
   logic [31:0] ctrl;
   logic [9:0]  free;
   logic [2:0]  lvl;
   logic        ie;
   logic        irq;
   logic        tx_valid;
   logic [7:0]  tx_data;
   logic        tx_ready;
   logic        tx_empty;

   always #2.5 clk = ~clk;

   tfq_tx_stage i_tfq_tx_stage (
      .clk_i        (clk),
      .rst_ni       (rst_n),
      .win_we_i     (win_we),
      .win_off_i    (win_off),
      .win_data_i   (win_data),
      .commit_we_i  (commit_we),
      .commit_cnt_i (commit_cnt),
      .ctrl_rdata_o (ctrl),
      .free_o       (free),
      .trig_lvl_i   (lvl),
      .space_ie_i   (ie),
      .space_irq_o  (irq),
      .tx_valid_o   (tx_valid),
      .tx_data_o    (tx_data),
      .tx_ready_i   (tx_ready),
      .tx_empty_o   (tx_empty)
   );

   // behavioural reference
   logic [7:0] m_mem [DEPTH];
   int m_w, m_r, m_fill;
   int n_chk = 0, n_fail = 0, cycles = 0;

   always @(posedge clk) begin : ref_model
      int g;
      bit acc;
      if (!rst_n) begin
         m_w = 0; m_r = 0; m_fill = 0;
      end else begin
         acc = (m_fill != 0) && tx_ready;
         if (win_we) m_mem[(m_w + int'(win_off)) % DEPTH] = win_data;
         g = 0;
         if (commit_we) begin
            g = int'(commit_cnt);
            if (g > LIMIT - m_fill) g = LIMIT - m_fill;
         end
         if (acc) m_r = (m_r + 1) % DEPTH;
         m_w = (m_w + g) % DEPTH;
         m_fill = m_fill + g - (acc ? 1 : 0);
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic check_all();
      chk("R3 write pointer", int'(ctrl[9:0]), m_w);
      chk("R3 fill count", int'(ctrl[25:16]), m_fill);
      chk("R3 unused status bits", int'({ctrl[31:26], ctrl[15:10]}), 0);
      chk("R4 free space", int'(free), LIMIT - m_fill);
      chk("R5 valid", int'(tx_valid), int'(m_fill != 0));
      if (m_fill != 0) chk("R5 byte order", int'(tx_data), int'(m_mem[m_r]));
      chk("R7 space irq", int'(irq), int'(ie && (m_fill <= (4 << lvl))));
      chk("R9 empty", int'(tx_empty), int'(m_fill == 0));
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
      check_all();
   endtask

   task automatic wr(input int off, input int data);
      win_we = 1'b1; win_off = 10'(off); win_data = 8'(data);
      step();
      win_we = 1'b0;
   endtask

   task automatic commit(input int n);
      commit_we = 1'b1; commit_cnt = 10'(n);
      step();
      commit_we = 1'b0;
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > WDOG) begin
         n_fail++;
         $display("FAIL watchdog on R5 drain actual=%0d cycles expected=below %0d", cycles, WDOG);
         summary();
      end
   end

   initial begin
      rst_n = 1'b0; win_we = 1'b0; win_off = '0; win_data = '0;
      commit_we = 1'b0; commit_cnt = '0; lvl = 3'd5; ie = 1'b0; tx_ready = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 fill after reset", int'(ctrl[25:16]), 0);
      chk("R1 wptr after reset", int'(ctrl[9:0]), 0);
      chk("R1 valid after reset", int'(tx_valid), 0);
      chk("R1 empty after reset", int'(tx_empty), 1);
      chk("R1 free after reset", int'(free), LIMIT);

      // R2 staged bytes stay invisible
      wr(0, 8'hA1); wr(1, 8'hB2); wr(2, 8'hC3);
      chk("R2 staged not offered", int'(tx_valid), 0);
      chk("R2 staged fill", int'(ctrl[25:16]), 0);

      // R3 commit
      commit(3);
      chk("R3 fill after commit", int'(ctrl[25:16]), 3);
      chk("R3 wptr after commit", int'(ctrl[9:0]), 3);

      // R5 ordered drain
      chk("R5 first byte", int'(tx_data), 8'hA1);
      tx_ready = 1'b1; step();
      chk("R5 second byte", int'(tx_data), 8'hB2);
      step();
      chk("R5 third byte", int'(tx_data), 8'hC3);
      step();
      chk("R5 drained", int'(tx_valid), 0);
      step();
      chk("R5 ready ignored when empty", int'(ctrl[25:16]), 0);
      tx_ready = 1'b0;

      commit(0);
      chk("R3 zero commit", int'(ctrl[9:0]), 3);

      // R4 clamping
      commit(1023);
      chk("R4 clamped fill", int'(ctrl[25:16]), LIMIT);
      chk("R4 clamped wptr", int'(ctrl[9:0]), 1023);
      commit(5);
      chk("R4 full commit refused", int'(ctrl[25:16]), LIMIT);
      chk("R4 no free space", int'(free), 0);

      // R7 threshold crossing at level 5 (128 bytes)
      ie = 1'b1; lvl = 3'd5; step();
      chk("R7 irq low when full", int'(irq), 0);
      tx_ready = 1'b1;
      while (m_fill > 129) step();
      chk("R7 irq low at 129", int'(irq), 0);
      step();
      chk("R7 irq high at 128", int'(irq), 1);
      tx_ready = 1'b0;
      lvl = 3'd7; step();
      chk("R7 level 7 threshold 512", int'(irq), 1);
      lvl = 3'd0; step();
      chk("R7 level 0 threshold 4", int'(irq), 0);
      ie = 1'b0; lvl = 3'd7; step();
      chk("R8 irq masked", int'(irq), 0);

      // R6 commit with simultaneous accept
      tx_ready = 1'b1; commit(10);
      chk("R6 commit and pop", int'(ctrl[25:16]), 137);
      while (m_fill > 0) step();
      tx_ready = 1'b0;

      // R2 and R5 across the pointer wrap
      commit(1010);
      tx_ready = 1'b1;
      while (m_fill > 0) step();
      tx_ready = 1'b0;
      for (int i = 0; i < 10; i++) wr(i, 8'h40 + i);
      commit(10);
      chk("R3 wptr wrapped", int'(ctrl[9:0]), (m_w));
      tx_ready = 1'b1;
      for (int i = 0; i < 10; i++) begin
         chk("R2 wrapped byte", int'(tx_data), 8'h40 + i);
         step();
      end
      tx_ready = 1'b0;

      // random traffic
      for (int c = 0; c < 4000; c++) begin
         win_we   = ($urandom % 2) == 0;
         win_off  = 10'($urandom % (DEPTH - m_fill));
         win_data = 8'($urandom);
         commit_we = ($urandom % 5) == 0;
         commit_cnt = (($urandom % 16) == 0) ? 10'($urandom) : 10'($urandom % 64);
         tx_ready = ($urandom % 5) < 3;
         ie  = ($urandom % 4) != 0;
         lvl = 3'($urandom);
         step();
      end
      win_we = 1'b0; commit_we = 1'b0;
      tx_ready = 1'b1;
      while (m_fill > 0) step();
      step();
      summary();
   end
endmodule